// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products logic array. Its data input is a set of product terms from the array. A per-term steering mask picks which of them join the sum, and the sum is their OR. A polarity bit can invert the sum. The result then either goes straight through or is captured in a one-bit register. That register is clocked by one of several global clocks, picked by a configuration field. It has a synchronous active-low reset and two asynchronous overrides, clear and set, which need no clock edge.

The cell drives an external pad. A drive value and a drive-enable come out separately, and the pad level comes back in. When the cell is not driving, that returned level shows up on a pin-input port. The cell also returns a feedback bit to the global interconnect. A configuration bit chooses whether the feedback carries the cell's own result or the pin-input value. With the feedback on the cell's result and the pad released as an input, the register stays buried: it keeps working and feeding the interconnect while the pad carries an unrelated signal. All configuration arrives as static input ports.

Top module: `pld_outcell`

## Requirements
- R1: The sum is the OR of the product terms whose steering-mask bit is 1. When no mask bit is set, the sum is 0.
- R2: With `cfg_invert` at 1 the sum is inverted before it reaches the register or the bypass path. With `cfg_invert` at 0 it passes unchanged.
- R3: With `cfg_bypass` at 1 the cell result is the polarity-adjusted sum, with no clock delay.
- R4: With `cfg_bypass` at 0 the cell result is the register. The register loads the polarity-adjusted sum only on a rising edge of `gclk[cfg_clk_sel]` (index 0 to NUM_CLKS-1). It holds through edges of the other global clocks.
- R5: A selected clock edge with `rst_n` at 0 loads 0 into the register. With `rst_n` low for a few cycles of clock 0, the register reads 0.
- R6: `async_clr` at 1 forces the register to 0 at once, without a clock edge. After release the 0 is held until the next selected edge.
- R7: `async_set` at 1 forces the register to 1 at once. When `async_clr` and `async_set` are both 1, the register is 0.
- R8: `pad_oe` follows `oe`, and `pad_drv` always carries the cell result.
- R9: With `oe` at 0, `pin_in` equals `pad_i`. With `oe` at 1, `pin_in` equals the driven value.
- R10: With `cfg_fb_pin` at 1, `fb` equals `pin_in`. With it at 0, `fb` carries the cell result, so a buried register keeps loading and feeding back while the pad is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NUM_CLKS | Global clocks |
| rst_n | input | 1 | Synchronous active-low register reset |
| pterm | input | NUM_TERMS | Product terms from the array |
| term_en | input | NUM_TERMS | Steering mask, 1 includes the term in the sum |
| cfg_invert | input | 1 | Invert the sum |
| cfg_bypass | input | 1 | 1 selects the combinational path, 0 the register |
| cfg_clk_sel | input | $clog2(NUM_CLKS) | Index of the global clock for the register |
| cfg_fb_pin | input | 1 | 1 feeds back pin-input, 0 feeds back the cell result |
| async_clr | input | 1 | Asynchronous clear, dominant |
| async_set | input | 1 | Asynchronous set |
| oe | input | 1 | Output-enable term |
| pad_i | input | 1 | Level returned from the pad |
| pad_drv | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| pin_in | output | 1 | Pin-input path to the interconnect |
| fb | output | 1 | Feedback to the global interconnect |

## Verification
On every edge of clock 0, the assertions check the following:
- the bypass path against the steering mask and the polarity bit, including the empty sum;
- the dominance of clear over set;
- the pin-input path for both states of `oe`;
- the feedback source;
- a one-cycle capture when clock 0 is the one selected.

Only the bench scenarios can show:
- that edges of the unselected clocks leave the register alone, across all four selections and four clock rates;
- the immediate mid-cycle effect of the asynchronous overrides, and the 0 held after clear is released;
- the buried register loading while the pad toggles as an input.

// File: rtl/pld_cell_pkg.sv
// Package: shared types for the configurable output cell.
// Assumes: nothing beyond IEEE 1800-2017.
package pld_cell_pkg;
    typedef enum logic {
        FB_FROM_CORE = 1'b0,
        FB_FROM_PAD  = 1'b1
    } fb_src_e;
endpackage

// File: rtl/pld_sum_path.sv
// Module: forms the steered OR of product terms and applies polarity.
// Assumes: term_en and cfg_invert are static configuration.
module pld_sum_path #(
    parameter int NUM_TERMS = 16
) (
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic [NUM_TERMS-1:0] term_en,
    input  logic                 cfg_invert,
    output logic                 sum_pol
);
    logic [NUM_TERMS-1:0] steered;

    // Gate each product term by its steering bit.
    generate
        for (genvar i = 0; i < NUM_TERMS; i++) begin : g_steer
            assign steered[i] = pterm[i] & term_en[i];
        end
    endgenerate

    // OR the steered terms; an empty sum is 0, then apply polarity.
    always_comb begin
        sum_pol = (|steered) ^ cfg_invert;
    end
endmodule

// File: rtl/pld_clk_pick.sv
// Module: selects one global clock for the cell register.
// Assumes: the select field is static while the clocks run.
module pld_clk_pick #(
    parameter int NUM_CLKS  = 4,
    localparam int SEL_W    = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
    input  logic [NUM_CLKS-1:0] gclk,
    input  logic [SEL_W-1:0]    sel,
    output logic                clk_out
);
    // Route the chosen global clock to the register.
    always_comb begin
        clk_out = gclk[sel];
    end
endmodule

// File: rtl/pld_cell_flop.sv
// Module: one-bit cell register with async clear/set and sync reset.
// Assumes: clear dominates set; both dominate the synchronous reset.
module pld_cell_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clr,
    input  logic async_set,
    input  logic d,
    output logic q
);
    // Capture d on the selected edge, honouring the overrides.
    always_ff @(posedge clk or posedge async_clr or posedge async_set) begin
        if (async_clr) begin
            q <= 1'b0;
        end else if (async_set) begin
            q <= 1'b1;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pld_pad_ctl.sv
// Module: pad drive control and pin-input path.
// Assumes: the pad reads back what it drives while enabled.
module pld_pad_ctl (
    input  logic oe,
    input  logic drive_val,
    input  logic pad_i,
    output logic pad_drv,
    output logic pad_oe,
    output logic pin_in
);
    // Drive value and enable toward the pad; pick the pin-input source.
    always_comb begin
        pad_drv = drive_val;
        pad_oe  = oe;
        pin_in  = oe ? drive_val : pad_i;
    end
endmodule

// File: rtl/pld_outcell.sv
// Module: configurable output cell (top).
// Combines sum forming, polarity, clock choice, register or bypass,
// pad control and a selectable feedback source.
// Assumes: all cfg_* and term_en inputs are static configuration.
module pld_outcell #(
    parameter int NUM_TERMS = 16,
    parameter int NUM_CLKS  = 4,
    localparam int SEL_W    = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
    input  logic [NUM_CLKS-1:0]  gclk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic [NUM_TERMS-1:0] term_en,
    input  logic                 cfg_invert,
    input  logic                 cfg_bypass,
    input  logic [SEL_W-1:0]     cfg_clk_sel,
    input  logic                 cfg_fb_pin,
    input  logic                 async_clr,
    input  logic                 async_set,
    input  logic                 oe,
    input  logic                 pad_i,
    output logic                 pad_drv,
    output logic                 pad_oe,
    output logic                 pin_in,
    output logic                 fb
);
    import pld_cell_pkg::*;

    logic    sum_pol;
    logic    reg_clk;
    logic    reg_q;
    logic    core_res;
    fb_src_e fb_src;

    pld_sum_path #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .pterm      (pterm),
        .term_en    (term_en),
        .cfg_invert (cfg_invert),
        .sum_pol    (sum_pol)
    );

    pld_clk_pick #(.NUM_CLKS(NUM_CLKS)) u_clk (
        .gclk    (gclk),
        .sel     (cfg_clk_sel),
        .clk_out (reg_clk)
    );

    pld_cell_flop u_flop (
        .clk       (reg_clk),
        .rst_n     (rst_n),
        .async_clr (async_clr),
        .async_set (async_set),
        .d         (sum_pol),
        .q         (reg_q)
    );

    // Choose between the registered and combinational result.
    always_comb begin
        core_res = cfg_bypass ? sum_pol : reg_q;
    end

    pld_pad_ctl u_pad (
        .oe        (oe),
        .drive_val (core_res),
        .pad_i     (pad_i),
        .pad_drv   (pad_drv),
        .pad_oe    (pad_oe),
        .pin_in    (pin_in)
    );

    // Pick the feedback source toward the interconnect.
    always_comb begin
        fb_src = cfg_fb_pin ? FB_FROM_PAD : FB_FROM_CORE;
        fb     = (fb_src == FB_FROM_PAD) ? pin_in : core_res;
    end
endmodule

// File: rtl/pld_outcell_chk.sv
// Module: assertion checker for pld_outcell, bound to every instance.
// Assumes: gclk[0] is a free-running clock usable for sampling.
module pld_outcell_chk #(
    parameter int NUM_TERMS = 16,
    parameter int NUM_CLKS  = 4,
    localparam int SEL_W    = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
    input logic [NUM_CLKS-1:0]  gclk,
    input logic                 rst_n,
    input logic [NUM_TERMS-1:0] pterm,
    input logic [NUM_TERMS-1:0] term_en,
    input logic                 cfg_invert,
    input logic                 cfg_bypass,
    input logic [SEL_W-1:0]     cfg_clk_sel,
    input logic                 cfg_fb_pin,
    input logic                 async_clr,
    input logic                 async_set,
    input logic                 oe,
    input logic                 pad_i,
    input logic                 pad_drv,
    input logic                 pad_oe,
    input logic                 pin_in,
    input logic                 fb
);
    logic exp_sum;
    assign exp_sum = (|(pterm & term_en)) ^ cfg_invert;

    a_r1_empty_sum: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (term_en == '0 && cfg_bypass) |-> pad_drv == cfg_invert);

    a_r3_bypass_path: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        cfg_bypass |-> pad_drv == exp_sum);

    a_r4_capture_clk0: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (cfg_clk_sel == '0 && !cfg_bypass && !async_clr && !async_set)
        |=> (cfg_bypass || async_clr || async_set || pad_drv == $past(exp_sum)));

    a_r7_clear_dominates: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (async_clr && !cfg_bypass) |-> pad_drv == 1'b0);

    a_r7_set_forces_one: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        (async_set && !async_clr && !cfg_bypass) |-> pad_drv == 1'b1);

    a_r9_pin_released: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        !oe |-> pin_in == pad_i);

    a_r9_pin_driven: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        oe |-> (pin_in == pad_drv && pad_oe));

    a_r10_fb_from_pin: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        cfg_fb_pin |-> fb == pin_in);

    a_r10_fb_from_core: assert property (@(posedge gclk[0]) disable iff (!rst_n)
        !cfg_fb_pin |-> fb == pad_drv);
endmodule

bind pld_outcell pld_outcell_chk #(
    .NUM_TERMS (NUM_TERMS),
    .NUM_CLKS  (NUM_CLKS)
) u_chk (
    .gclk        (gclk),
    .rst_n       (rst_n),
    .pterm       (pterm),
    .term_en     (term_en),
    .cfg_invert  (cfg_invert),
    .cfg_bypass  (cfg_bypass),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_fb_pin  (cfg_fb_pin),
    .async_clr   (async_clr),
    .async_set   (async_set),
    .oe          (oe),
    .pad_i       (pad_i),
    .pad_drv     (pad_drv),
    .pad_oe      (pad_oe),
    .pin_in      (pin_in),
    .fb          (fb)
);

// File: tb/pld_outcell_bench.sv
// Bench: behavioural reference model compared after every clock.
// Global clock k pulses on every (k+1)-th cycle of the 250 MHz clock.
module pld_outcell_bench;
    localparam int NT = 16;
    localparam int NC = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;

    logic [NC-1:0] gclk;
    always_comb begin
        for (int k = 0; k < NC; k++) gclk[k] = clk && ((cyc % (k + 1)) == 0);
    end

    logic          rst_n = 1'b0;
    logic [NT-1:0] pterm = '0;
    logic [NT-1:0] term_en = '0;
    logic          cfg_invert = 1'b0;
    logic          cfg_bypass = 1'b0;
    logic [SW-1:0] cfg_clk_sel = '0;
    logic          cfg_fb_pin = 1'b0;
    logic          async_clr = 1'b0;
    logic          async_set = 1'b0;
    logic          oe = 1'b0;
    logic          pad_i = 1'b0;
    logic          pad_drv, pad_oe, pin_in, fb;

    pld_outcell #(.NUM_TERMS(NT), .NUM_CLKS(NC)) u_pld_outcell (
        .gclk(gclk), .rst_n(rst_n), .pterm(pterm), .term_en(term_en),
        .cfg_invert(cfg_invert), .cfg_bypass(cfg_bypass),
        .cfg_clk_sel(cfg_clk_sel), .cfg_fb_pin(cfg_fb_pin),
        .async_clr(async_clr), .async_set(async_set), .oe(oe), .pad_i(pad_i),
        .pad_drv(pad_drv), .pad_oe(pad_oe), .pin_in(pin_in), .fb(fb)
    );

    int    total = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_tag = "R5";

    // Reference sum: any enabled term that is high, then polarity.
    function automatic logic model_sum();
        logic any = 1'b0;
        for (int i = 0; i < NT; i++) if (term_en[i] && pterm[i]) any = 1'b1;
        return cfg_invert ? !any : any;
    endfunction

    logic ref_q = 1'b0;
    always @(posedge clk) begin
        if (async_clr) ref_q <= 1'b0;
        else if (async_set) ref_q <= 1'b1;
        else if ((cyc % (int'(cfg_clk_sel) + 1)) == 0) ref_q <= rst_n ? model_sum() : 1'b0;
    end

    task automatic check1(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic chk_all();
        logic q_e, res_e, pin_e, fb_e;
        q_e   = async_clr ? 1'b0 : (async_set ? 1'b1 : ref_q);
        res_e = cfg_bypass ? model_sum() : q_e;
        pin_e = oe ? res_e : pad_i;
        fb_e  = cfg_fb_pin ? pin_e : res_e;
        check1(cur_tag, "pad_drv", pad_drv, res_e);
        check1(cur_tag, "pad_oe", pad_oe, oe);
        check1(cur_tag, "pin_in", pin_in, pin_e);
        check1(cur_tag, "fb", fb, fb_e);
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            chk_all();
        end
    endtask

    initial begin
        // R5: reset state with the register on clock 0.
        cur_tag = "R5";
        tick(3);
        check1("R5", "fb after reset", fb, 1'b0);
        rst_n = 1'b1;

        // R1: empty sum and steered sums on the bypass path.
        cur_tag = "R1";
        cfg_bypass = 1'b1;
        pterm = '1;
        term_en = '0;
        tick(1);
        check1("R1", "empty sum", fb, 1'b0);
        term_en = 16'h0100;
        pterm = 16'h0100;
        tick(1);
        check1("R1", "one term", fb, 1'b1);
        pterm = 16'hFEFF;
        tick(1);
        check1("R1", "masked terms", fb, 1'b0);
        for (int i = 0; i < 12; i++) begin
            pterm = NT'($urandom);
            term_en = NT'($urandom);
            tick(1);
        end

        // R2 and R3: polarity on the combinational path.
        cur_tag = "R2";
        cfg_invert = 1'b1;
        term_en = '0;
        tick(1);
        check1("R2", "inverted empty", fb, 1'b1);
        cur_tag = "R3";
        for (int i = 0; i < 10; i++) begin
            cfg_invert = 1'($urandom);
            pterm = NT'($urandom);
            term_en = NT'($urandom);
            tick(1);
        end

        // R4: registered path under each clock selection.
        cur_tag = "R4";
        cfg_bypass = 1'b0;
        cfg_invert = 1'b0;
        for (int s = 0; s < NC; s++) begin
            cfg_clk_sel = SW'(s);
            for (int i = 0; i < 16; i++) begin
                pterm = NT'($urandom);
                term_en = NT'($urandom) | 16'h0001;
                tick(1);
            end
        end

        // R5: synchronous reset through the selected clock.
        cur_tag = "R5";
        cfg_clk_sel = '0;
        term_en = '1;
        pterm = '1;
        tick(2);
        check1("R5", "loaded one", fb, 1'b1);
        rst_n = 1'b0;
        tick(1);
        check1("R5", "sync cleared", fb, 1'b0);
        rst_n = 1'b1;
        tick(1);

        // R6: asynchronous clear acts mid-cycle and holds after release.
        cur_tag = "R6";
        cfg_clk_sel = 2'd3;
        async_clr = 1'b1;
        #1;
        check1("R6", "clear immediate", fb, 1'b0);
        tick(1);
        async_clr = 1'b0;
        term_en = '0;
        tick(5);

        // R7: asynchronous set, then both at once.
        cur_tag = "R7";
        async_set = 1'b1;
        #1;
        check1("R7", "set immediate", fb, 1'b1);
        tick(1);
        async_clr = 1'b1;
        #1;
        check1("R7", "clear wins", fb, 1'b0);
        tick(2);
        async_clr = 1'b0;
        async_set = 1'b0;
        tick(4);

        // R8 and R9: drive enable and the pin-input path.
        cur_tag = "R8";
        cfg_clk_sel = 2'd1;
        term_en = '1;
        for (int i = 0; i < 8; i++) begin
            oe = 1'($urandom);
            pad_i = 1'($urandom);
            pterm = NT'($urandom);
            tick(1);
        end
        cur_tag = "R9";
        oe = 1'b0;
        pad_i = 1'b1;
        tick(1);
        check1("R9", "released pin", pin_in, 1'b1);
        oe = 1'b1;
        pterm = '0;
        tick(2);
        check1("R9", "driven pin", pin_in, 1'b0);

        // R10: pin feedback and the buried register.
        cur_tag = "R10";
        oe = 1'b0;
        cfg_fb_pin = 1'b1;
        pad_i = 1'b0;
        pterm = '1;
        tick(2);
        check1("R10", "fb from pin", fb, 1'b0);
        cfg_fb_pin = 1'b0;
        cfg_clk_sel = 2'd2;
        for (int i = 0; i < 18; i++) begin
            pad_i = 1'($urandom);
            pterm = NT'($urandom);
            tick(1);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog all requirements: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule